// File: doc/BRIEF.md
# Table-Programmed Push-Button Lock

The block is a push-button lock whose whole behaviour sits in a 64-word by 4-bit lookup table. It has three one-cycle button pulses: clear, zero and one. On every clock cycle the current 3-bit state and the three button levels form a 6-bit table address. The word read there gives the next state, which loads on the next rising edge, and an unlock level that drives the output straight away. The entry code, the hold when no button is pressed, the hold when both digit buttons are pressed and the relock behaviour are all table contents. Changing the table parameter therefore gives another lock without any change to the logic.

The default contents open the lock after a clear press followed by zero and then one. Any other digit order falls into a locked trap state, and only a clear press leaves it. Once reached, the open state stays open for digit presses. A separate synchronous init input puts the state register into the locked idle state. The buttons are plain control levels, each assumed stable around the rising edge. The block has no data stream, so it has no valid/ready handshake and no back-pressure: the block takes one table step on every cycle.

Top module: `lock_rom_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the state register loads 000 (locked idle), and `unlock` reads 0 with no button pressed.
- R2: The table address is {state[2:0], clear, one, zero}: bits 5..3 hold the state, bit 2 the clear button, bit 1 the one button and bit 0 the zero button.
- R3: Bits 2..0 of the addressed word load into the state register at the next rising edge. Bit 3 of that word drives `unlock` in the same cycle.
- R4: With the default table, `unlock` is 1 exactly when the state is 011 (open), whatever buttons are pressed.
- R5: With the default table, a clear press moves any state to 000 at the next edge, whatever the digit buttons do.
- R6: With the default table, a cycle with no button pressed leaves the state unchanged.
- R7: With the default table, zero and one pressed together without clear leave the state unchanged.
- R8: With the default table, clear, then zero, then one reaches state 011 and sets `unlock` to 1.
- R9: With the default table, a wrong digit moves the lock to trap state 010. A wrong digit is one, or two presses of zero, before the code completes. The trap holds for digit presses, so every four-press digit sequence after clear that does not begin zero, one stays locked. All words not set by the rules above hold 0010.
- R10: With the default table, a single zero or one press in state 011 keeps the state at 011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous init to locked idle, active high |
| btn_clear | input | 1 | Clear button pulse |
| btn_zero | input | 1 | Zero digit button pulse |
| btn_one | input | 1 | One digit button pulse |
| unlock | output | 1 | Unlock level from bit 3 of the addressed word |
| state_o | output | 3 | Current lock state |

## Verification
The default table is swept over every reachable state and all eight button combinations. This sweep separates the clear priority, the two hold cases and the single-digit transitions. A second instance carries an arithmetic table: its next state is the state plus the 3-bit button code, and its unlock is state bit 2 XOR the zero button. Sweeping all 64 addresses of that table confirms the address bit order and the word field split, and the default table would hide mistakes in either. All sixteen four-digit sequences after a clear check that only a zero, one prefix opens the lock.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int STATE_W    = 3;
  localparam int BTN_W      = 3;
  localparam int ADDR_W     = STATE_W + BTN_W;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int WORD_W     = STATE_W + 1;
  localparam int TABLE_BITS = DEPTH * WORD_W;

  localparam logic [STATE_W-1:0] ST_IDLE = 3'b000;
  localparam logic [STATE_W-1:0] ST_GOT0 = 3'b001;
  localparam logic [STATE_W-1:0] ST_TRAP = 3'b010;
  localparam logic [STATE_W-1:0] ST_OPEN = 3'b011;

  // Default contents: clear, zero, one opens; wrong digits trap.
  function automatic logic [TABLE_BITS-1:0] default_table();
    logic [TABLE_BITS-1:0] t;
    logic [ADDR_W-1:0]     ad;
    logic [STATE_W-1:0]    s;
    logic [STATE_W-1:0]    nx;
    logic                  clr, one, zro, ul;
    t = '0;
    for (int a = 0; a < DEPTH; a++) begin
      ad  = ADDR_W'(a);
      s   = ad[ADDR_W-1:BTN_W];
      clr = ad[2];
      one = ad[1];
      zro = ad[0];
      ul  = (s == ST_OPEN);
      nx  = ST_TRAP;
      if (clr) begin
        nx = ST_IDLE;
      end else if (one == zro) begin
        nx = s;
      end else begin
        case (s)
          ST_IDLE: nx = zro ? ST_GOT0 : ST_TRAP;
          ST_GOT0: nx = one ? ST_OPEN : ST_TRAP;
          ST_OPEN: nx = ST_OPEN;
          default: nx = ST_TRAP;
        endcase
      end
      t[a*WORD_W +: WORD_W] = {ul, nx};
    end
    return t;
  endfunction
endpackage

// File: rtl/lock_addr.sv
module lock_addr #(
  parameter int STATE_W = 3,
  parameter int ADDR_W  = STATE_W + 3
) (
  input  logic [STATE_W-1:0] state_i,
  input  logic               clear_i,
  input  logic               one_i,
  input  logic               zero_i,
  output logic [ADDR_W-1:0]  addr_o
);
  // Bit order is behaviour: table contents decode it.
  assign addr_o = {state_i, clear_i, one_i, zero_i};
endmodule

// File: rtl/lock_table.sv
module lock_table #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  parameter logic [DEPTH*WORD_W-1:0] CONTENTS = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = CONTENTS[i*WORD_W +: WORD_W];
  end

  assign word_o = mem[addr_i];
endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg #(
  parameter int STATE_W = 3,
  parameter logic [STATE_W-1:0] INIT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] next_i,
  output logic [STATE_W-1:0] state_o
);
  always_ff @(posedge clk) begin
    if (rst) state_o <= INIT;
    else     state_o <= next_i;
  end
endmodule

// File: rtl/lock_rom_fsm.sv
module lock_rom_fsm #(
  parameter logic [lock_pkg::TABLE_BITS-1:0] TABLE = lock_pkg::default_table()
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         btn_clear,
  input  logic                         btn_zero,
  input  logic                         btn_one,
  output logic                         unlock,
  output logic [lock_pkg::STATE_W-1:0] state_o
);
  import lock_pkg::*;

  localparam bit IS_DEFAULT = (TABLE == default_table());

  logic [STATE_W-1:0] state_q;
  logic [ADDR_W-1:0]  addr;
  logic [WORD_W-1:0]  word;
  logic [STATE_W-1:0] next_state;

  lock_addr #(.STATE_W(STATE_W), .ADDR_W(ADDR_W)) u_addr (
    .state_i (state_q),
    .clear_i (btn_clear),
    .one_i   (btn_one),
    .zero_i  (btn_zero),
    .addr_o  (addr)
  );

  lock_table #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CONTENTS(TABLE)) u_table (
    .addr_i (addr),
    .word_o (word)
  );

  assign next_state = word[STATE_W-1:0];
  assign unlock     = word[WORD_W-1];
  assign state_o    = state_q;

  lock_state_reg #(.STATE_W(STATE_W), .INIT(ST_IDLE)) u_state (
    .clk     (clk),
    .rst     (rst),
    .next_i  (next_state),
    .state_o (state_q)
  );

  // R1
  init_idle_chk: assert property (@(posedge clk) rst |=> state_q == ST_IDLE);

  if (IS_DEFAULT) begin : g_default_chk
    // R4
    unlock_state_only_chk: assert property (@(posedge clk) disable iff (rst)
      unlock == (state_q == ST_OPEN));
    // R5
    clear_relock_chk: assert property (@(posedge clk) disable iff (rst)
      btn_clear |=> state_q == ST_IDLE);
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!btn_clear && !btn_zero && !btn_one) |=> $stable(state_q));
    // R7
    both_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!btn_clear && btn_zero && btn_one) |=> $stable(state_q));
    // R10
    open_loop_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_OPEN && !btn_clear) |=> state_q == ST_OPEN);
  end
endmodule

// File: tb/tb_lock_rom_fsm.sv
module tb_lock_rom_fsm;
  import lock_pkg::*;

  // Arithmetic table: next = state + buttons, unlock = state[2] ^ zero.
  function automatic logic [TABLE_BITS-1:0] alt_table();
    logic [TABLE_BITS-1:0] t;
    logic [5:0] ad;
    logic [2:0] nx;
    t = '0;
    for (int a = 0; a < DEPTH; a++) begin
      ad = 6'(a);
      nx = ad[5:3] + ad[2:0];
      t[a*4 +: 4] = {ad[5] ^ ad[0], nx};
    end
    return t;
  endfunction

  localparam logic [TABLE_BITS-1:0] ALT = alt_table();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] btn = 3'b000;      // {clear, one, zero}
  logic [2:0] btn_a = 3'b000;
  logic unlock, unlock_a;
  logic [2:0] st, st_a;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lock_rom_fsm dut (
    .clk(clk), .rst(rst), .btn_clear(btn[2]), .btn_zero(btn[0]),
    .btn_one(btn[1]), .unlock(unlock), .state_o(st)
  );

  lock_rom_fsm #(.TABLE(ALT)) dut_alt (
    .clk(clk), .rst(rst), .btn_clear(btn_a[2]), .btn_zero(btn_a[0]),
    .btn_one(btn_a[1]), .unlock(unlock_a), .state_o(st_a)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_init();
    @(negedge clk); rst = 1'b1; btn = 3'b000; btn_a = 3'b000;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic press(logic [2:0] b);
    btn = b;
    @(negedge clk);
    btn = 3'b000;
  endtask

  task automatic press_a(logic [2:0] b);
    btn_a = b;
    @(negedge clk);
    btn_a = 3'b000;
  endtask

  // Expected next state of the default table, from R5..R10.
  function automatic logic [2:0] model_next(logic [2:0] s, logic [2:0] b);
    if (b[2]) return 3'b000;
    if (b[1] == b[0]) return s;
    if (s == 3'b000) return b[0] ? 3'b001 : 3'b010;
    if (s == 3'b001) return b[1] ? 3'b011 : 3'b010;
    if (s == 3'b011) return 3'b011;
    return 3'b010;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] reach [4];
    reach[0] = 3'b000; reach[1] = 3'b001; reach[2] = 3'b010; reach[3] = 3'b011;

    // R1: init state
    do_init();
    check("R1 state", {5'b0, st}, 8'h00);
    check("R1 unlock", {7'b0, unlock}, 8'h00);

    // R4..R7, R10: default table, reachable states x all button codes
    for (int si = 0; si < 4; si++) begin
      for (int b = 0; b < 8; b++) begin
        do_init();
        if (reach[si] == 3'b001) press(3'b001);
        if (reach[si] == 3'b010) press(3'b010);
        if (reach[si] == 3'b011) begin press(3'b001); press(3'b010); end
        btn = 3'(b);
        #1;
        check("R4 unlock vs state", {7'b0, unlock}, {7'b0, reach[si] == 3'b011});
        @(negedge clk);
        btn = 3'b000;
        check("R5 R6 R7 R9 R10 next", {5'b0, st}, {5'b0, model_next(reach[si], 3'(b))});
      end
    end

    // R8: code opens
    do_init();
    press(3'b100); press(3'b001); press(3'b010);
    check("R8 state", {5'b0, st}, 8'h03);
    check("R8 unlock", {7'b0, unlock}, 8'h01);
    // R1: init relocks an open lock
    do_init();
    check("R1 relock", {7'b0, unlock}, 8'h00);

    // R9: all four-digit sequences after clear
    for (int q = 0; q < 16; q++) begin
      logic [3:0] seq;
      seq = 4'(q);
      do_init();
      press(3'b100);
      for (int k = 0; k < 4; k++) press(seq[k] ? 3'b010 : 3'b001);
      check("R9 sequence unlock", {7'b0, unlock},
            {7'b0, (seq[0] == 1'b0) && (seq[1] == 1'b1)});
    end

    // R2 R3: arithmetic table, all 64 addresses
    for (int s = 0; s < 8; s++) begin
      for (int b = 0; b < 8; b++) begin
        logic [2:0] sv, bv, ex;
        sv = 3'(s); bv = 3'(b); ex = sv + bv;
        do_init();
        press_a(sv);
        btn_a = bv;
        #1;
        check("R2 R3 alt unlock", {7'b0, unlock_a}, {7'b0, sv[2] ^ bv[0]});
        @(negedge clk);
        btn_a = 3'b000;
        check("R2 R3 alt next", {5'b0, st_a}, {5'b0, ex});
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule